// File: doc/BRIEF.md
# Aliased Set/Merge Interrupt Control Register

This block holds one 64-bit control word behind a register bus that only takes full 8-byte accesses. The word can be reached at three consecutive word offsets (byte address shifted right by three). The first offset overwrites the word, the third ORs the write data into it, and the middle one depends on a build-time variant. In the merge variant it ANDs the write data into the word. In the clear variant it zeroes the word and discards the write data. Only the 19 most significant bits are implemented. Bits are numbered from the MSB, so bit 0 is data bit 63. Every update result is masked to those 19 bits.

The most significant bit drives a level interrupt output. That output reflects the stored bit at all times. Internal logic can pulse a message strobe, which sets the interrupt bit and a shared-message bit (bit 3 from the MSB, data bit 60) in one step. A bus write in the same cycle is applied first, and the strobe bits are then ORed into the result. Any access the block does not implement returns zero, changes nothing and raises a one-cycle debug flag. Read data is registered.

Top module: `alias_irq_reg`

## Requirements
- R1: After reset the stored word is zero, the interrupt output is low, and a read of the plain offset returns zero.
- R2: A read raises the read-valid output exactly one cycle after the request. Read data then holds the stored word as it stood before any update made in the request cycle. A write request leaves read-valid low.
- R3: In the merge variant (MODE=0), a write to word offset 0x4021 replaces the word with the old value ANDed with the write data.
- R4: A write to the OR offset (0x4022 for MODE=0, 0x6082 for MODE=1) replaces the word with the old value ORed with the write data.
- R5: In the clear variant (MODE=1), a write to word offset 0x6081 sets the word to zero whatever the write data is.
- R6: Only data bits 63 down to 45 hold state. Every update result is masked so that bits 44..0 always read back as zero.
- R7: The interrupt output equals stored data bit 63 in every cycle and stays at that level until the word changes.
- R8: A message strobe ORs data bits 63 and 60 into the word, so the interrupt is high from the following cycle.
- R9: When a bus write and the message strobe fall in the same cycle, the write result is formed first and then bits 63 and 60 are ORed into it.
- R10: A read of any word offset other than the plain offset (0x4020 for MODE=0, 0x6080 for MODE=1) returns zero. A write to any offset outside the three aliases leaves the word unchanged. Both raise the unimplemented flag one cycle after the request.
- R11: An access whose size input is not 8 bytes, or whose byte address is not 8-byte aligned, writes nothing, reads zero and raises the unimplemented flag one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (20) | Byte address; word offset is bits [ADDR_W-1:3] |
| bus_size | input | SIZE_W (4) | Access size in bytes; only 8 is accepted |
| bus_wdata | input | DATA_W (64) | Write data |
| msg_raise | input | 1 | Internal message strobe |
| rd_data | output | DATA_W (64) | Registered read data |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| irq_out | output | 1 | Level interrupt, follows stored data bit 63 |
| unimpl_flag | output | 1 | One-cycle pulse after an unimplemented or malformed access |

## Verification
The bench attacks the write/strobe collision with a plain write of a value that lacks bit 63. A design that applied the strobe before the write would lose the strobe bits and leave the interrupt low. It also writes all ones to catch a missing mask, and sends a clear-alias write with all-ones data to catch a clear that merges data instead of discarding it. Reads of the AND/OR aliases, reads of the other variant's offsets, short accesses and misaligned accesses all check that nothing leaks into the word or the read data and that the debug flag fires. Both variants are built side by side on one shared bus, and a behavioural model is compared against their outputs every cycle.

// File: rtl/alias_irq_pkg.sv
`timescale 1ns/1ps
package alias_irq_pkg;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_PLAIN = 3'd1,
        OP_AND   = 3'd2,
        OP_OR    = 3'd3,
        OP_CLEAR = 3'd4
    } wr_op_e;

    localparam int unsigned WORD_BASE_MERGE = 32'h4020;
    localparam int unsigned WORD_BASE_CLEAR = 32'h6080;

endpackage

// File: rtl/alias_addr_decode.sv
`timescale 1ns/1ps
module alias_addr_decode
    import alias_irq_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int SIZE_W     = 4,
    parameter int FULL_BYTES = 8,
    parameter int MODE       = 0
) (
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [SIZE_W-1:0] size,
    output wr_op_e            op,
    output logic              rd_hit,
    output logic              unimpl
);
    localparam int OFF_W = ADDR_W - 3;
    localparam int unsigned BASE_WORD = (MODE == 0) ? WORD_BASE_MERGE : WORD_BASE_CLEAR;
    localparam logic [OFF_W-1:0] OFF_PLAIN = OFF_W'(BASE_WORD);
    localparam logic [OFF_W-1:0] OFF_MID   = OFF_W'(BASE_WORD + 1);
    localparam logic [OFF_W-1:0] OFF_OR    = OFF_W'(BASE_WORD + 2);

    wr_op_e mid_op;

    generate
        if (MODE == 0) begin : g_mid_and
            assign mid_op = OP_AND;
        end else begin : g_mid_clear
            assign mid_op = OP_CLEAR;
        end
    endgenerate

    logic [OFF_W-1:0] off;
    logic             legal;

    always_comb begin
        off    = addr[ADDR_W-1:3];
        legal  = (size == SIZE_W'(FULL_BYTES)) && (addr[2:0] == 3'b000);
        op     = OP_NONE;
        rd_hit = 1'b0;
        unimpl = 1'b0;
        if (req) begin
            if (!legal) begin
                unimpl = 1'b1;
            end else if (we) begin
                if (off == OFF_PLAIN)      op = OP_PLAIN;
                else if (off == OFF_MID)   op = mid_op;
                else if (off == OFF_OR)    op = OP_OR;
                else                       unimpl = 1'b1;
            end else begin
                if (off == OFF_PLAIN)      rd_hit = 1'b1;
                else                       unimpl = 1'b1;
            end
        end
    end

endmodule

// File: rtl/alias_merge_unit.sv
`timescale 1ns/1ps
module alias_merge_unit
    import alias_irq_pkg::*;
#(
    parameter int DATA_W    = 64,
    parameter int IMPL_BITS = 19
) (
    input  logic [DATA_W-1:0] cur,
    input  logic [DATA_W-1:0] wdata,
    input  wr_op_e            op,
    input  logic              raise,
    output logic [DATA_W-1:0] nxt
);
    localparam logic [DATA_W-1:0] IMPL_MASK  = ~({DATA_W{1'b1}} >> IMPL_BITS);
    localparam logic [DATA_W-1:0] RAISE_BITS = (DATA_W'(1) << (DATA_W - 1))
                                             | (DATA_W'(1) << (DATA_W - 4));

    logic [DATA_W-1:0] merged;

    always_comb begin
        unique case (op)
            OP_PLAIN: merged = wdata;
            OP_AND:   merged = cur & wdata;
            OP_OR:    merged = cur | wdata;
            OP_CLEAR: merged = '0;
            default:  merged = cur;
        endcase
        if (raise) merged = merged | RAISE_BITS;
        nxt = merged & IMPL_MASK;
    end

endmodule

// File: rtl/alias_irq_reg.sv
`timescale 1ns/1ps
module alias_irq_reg
    import alias_irq_pkg::*;
#(
    parameter int DATA_W    = 64,
    parameter int IMPL_BITS = 19,
    parameter int ADDR_W    = 20,
    parameter int SIZE_W    = 4,
    parameter int MODE      = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [SIZE_W-1:0] bus_size,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              msg_raise,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              irq_out,
    output logic              unimpl_flag
);
    localparam int FULL_BYTES = DATA_W / 8;
    localparam int IRQ_BIT    = DATA_W - 1;
    localparam int MSG_BIT    = DATA_W - 4;
    localparam int LOW_W      = DATA_W - IMPL_BITS;

    typedef struct packed {
        logic [DATA_W-1:0] val;
        logic [DATA_W-1:0] rd;
        logic              rv;
        logic              un;
    } state_t;

    state_t state_d, state_q;
    wr_op_e op;
    logic   rd_hit, unimpl;
    logic [DATA_W-1:0] merged;

    alias_addr_decode #(
        .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .FULL_BYTES(FULL_BYTES), .MODE(MODE)
    ) u_dec (
        .req(bus_req), .we(bus_we), .addr(bus_addr), .size(bus_size),
        .op(op), .rd_hit(rd_hit), .unimpl(unimpl)
    );

    alias_merge_unit #(
        .DATA_W(DATA_W), .IMPL_BITS(IMPL_BITS)
    ) u_merge (
        .cur(state_q.val), .wdata(bus_wdata), .op(op), .raise(msg_raise), .nxt(merged)
    );

    always_comb begin
        state_d     = state_q;
        state_d.val = merged;
        state_d.rd  = rd_hit ? state_q.val : '0;
        state_d.rv  = bus_req && !bus_we;
        state_d.un  = unimpl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign rd_data     = state_q.rd;
    assign rd_valid    = state_q.rv;
    assign irq_out     = state_q.val[IRQ_BIT];
    assign unimpl_flag = state_q.un;

    // R8, R9: strobe bits are present after any update that carried the strobe
    a_r8_raise_sets_bits: assert property (@(posedge clk) disable iff (!rst_n)
        msg_raise |=> (irq_out && state_q.val[MSG_BIT]));

    // R6: unimplemented low bits never hold state
    a_r6_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.val[LOW_W-1:0] == '0);

    // R2: read valid follows a read request by one cycle
    a_r2_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we) |=> rd_valid);

    // R10: flagged reads return zero
    a_r10_unimpl_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && unimpl_flag) |-> (rd_data == '0));

    // R11: malformed accesses without the strobe leave the word alone
    a_r11_bad_size_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && !msg_raise && (bus_size != SIZE_W'(FULL_BYTES)))
        |=> ($stable(state_q.val) && unimpl_flag));

    generate
        if (MODE == 0) begin : g_chk_and
            // R3: AND alias never sets a bit the write data lacks
            a_r3_and_subset: assert property (@(posedge clk) disable iff (!rst_n)
                (op == OP_AND && !msg_raise) |=> ((state_q.val & ~$past(bus_wdata)) == '0));
        end else begin : g_chk_clear
            // R5: clear alias empties the word
            a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
                (op == OP_CLEAR && !msg_raise) |=> (state_q.val == '0 && !irq_out));
        end
    endgenerate

endmodule

// File: tb/sim_alias_irq_reg.sv
`timescale 1ns/1ps
module sim_alias_irq_reg;

    localparam longint unsigned MASK  = 64'hFFFF_E000_0000_0000;
    localparam longint unsigned RBITS = 64'h9000_0000_0000_0000;
    localparam int unsigned A0 = 32'h4020;
    localparam int unsigned A1 = 32'h6080;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, we = 1'b0, raise = 1'b0;
    logic [19:0] addr = '0;
    logic [3:0]  size = 4'd8;
    logic [63:0] wdata = '0;

    logic [63:0] rd0, rd1;
    logic        rv0, rv1, irq0, irq1, un0, un1;

    int n_chk = 0;
    int n_bad = 0;
    bit started = 1'b0;

    always #4 clk = ~clk;

    alias_irq_reg #(.MODE(0)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_req(req), .bus_we(we), .bus_addr(addr),
        .bus_size(size), .bus_wdata(wdata), .msg_raise(raise),
        .rd_data(rd0), .rd_valid(rv0), .irq_out(irq0), .unimpl_flag(un0));

    alias_irq_reg #(.MODE(1)) u1 (
        .clk(clk), .rst_n(rst_n), .bus_req(req), .bus_we(we), .bus_addr(addr),
        .bus_size(size), .bus_wdata(wdata), .msg_raise(raise),
        .rd_data(rd1), .rd_valid(rv1), .irq_out(irq1), .unimpl_flag(un1));

    // behavioural reference model
    longint unsigned mv  [2];
    longint unsigned erd [2];
    bit              erv [2];
    bit              eun [2];

    task automatic model_step(int i, int unsigned base, bit clr);
        int unsigned     off;
        bit              legal;
        longint unsigned nv;
        off   = int'(addr >> 3);
        legal = (size == 4'd8) && (addr[2:0] == 3'b000);
        nv    = mv[i];
        erd[i] = 0;
        eun[i] = 0;
        erv[i] = req && !we;
        if (req) begin
            if (!legal) eun[i] = 1;
            else if (we) begin
                if (off == base)          nv = wdata;
                else if (off == base + 1) nv = clr ? 64'd0 : (mv[i] & wdata);
                else if (off == base + 2) nv = mv[i] | wdata;
                else                      eun[i] = 1;
            end else begin
                if (off == base) erd[i] = mv[i];
                else             eun[i] = 1;
            end
        end
        if (raise) nv = nv | RBITS;
        mv[i] = nv & MASK;
    endtask

    always @(posedge clk) begin
        started <= 1'b1;
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) begin
                mv[i] = 0; erd[i] = 0; erv[i] = 0; eun[i] = 0;
            end
        end else begin
            model_step(0, A0, 1'b0);
            model_step(1, A1, 1'b1);
        end
    end

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (started) begin
            chk("R7 irq u0", 64'(irq0), 64'(mv[0][63]));
            chk("R7 irq u1", 64'(irq1), 64'(mv[1][63]));
            chk("R2 rd_valid u0", 64'(rv0), 64'(erv[0]));
            chk("R2 rd_valid u1", 64'(rv1), 64'(erv[1]));
            chk("R2 rd_data u0", rd0, erd[0]);
            chk("R2 rd_data u1", rd1, erd[1]);
            chk("R10 unimpl u0", 64'(un0), 64'(eun[0]));
            chk("R10 unimpl u1", 64'(un1), 64'(eun[1]));
        end
    end

    task automatic op(bit w, int unsigned word, logic [2:0] lo, logic [3:0] sz,
                      logic [63:0] d, bit r);
        @(negedge clk);
        req = 1'b1; we = w; addr = {word[16:0], lo}; size = sz; wdata = d; raise = r;
        @(negedge clk);
        req = 1'b0; we = 1'b0; raise = 1'b0; wdata = '0; size = 4'd8;
    endtask

    task automatic wr(int unsigned word, logic [63:0] d);
        op(1'b1, word, 3'd0, 4'd8, d, 1'b0);
    endtask

    task automatic rd(int unsigned word);
        op(1'b0, word, 3'd0, 4'd8, 64'd0, 1'b0);
    endtask

    task automatic pulse_raise();
        @(negedge clk);
        raise = 1'b1;
        @(negedge clk);
        raise = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(A0);
        chk("R1 reset read u0", rd0, 64'd0);
        chk("R1 reset irq u0", 64'(irq0), 64'd0);

        // R6 masking, R7 irq high
        wr(A0, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(A0);
        chk("R6 masked value", rd0, 64'hFFFF_E000_0000_0000);
        chk("R7 irq set", 64'(irq0), 64'd1);
        chk("R2 read valid", 64'(rv0), 64'd1);

        // R3 AND merge
        wr(A0 + 1, 64'h0F0F_0F0F_0F0F_0F0F);
        chk("R7 irq dropped", 64'(irq0), 64'd0);
        chk("R2 write no valid", 64'(rv0), 64'd0);
        rd(A0);
        chk("R3 and merge", rd0, 64'h0F0F_0000_0000_0000);

        // R4 OR merge
        wr(A0 + 2, 64'h8000_0000_0000_0001);
        rd(A0);
        chk("R4 or merge", rd0, 64'h8F0F_0000_0000_0000);
        chk("R7 irq level", 64'(irq0), 64'd1);

        // R8 message strobe
        wr(A0, 64'd0);
        pulse_raise();
        chk("R8 raise irq", 64'(irq0), 64'd1);
        rd(A0);
        chk("R8 raise bits", rd0, RBITS);

        // R9 write and strobe together
        op(1'b1, A0, 3'd0, 4'd8, 64'h4000_0000_0000_0000, 1'b1);
        rd(A0);
        chk("R9 write then strobe", rd0, 64'hD000_0000_0000_0000);

        // R10 unimplemented read and write
        rd(A0 + 1);
        chk("R10 alias read zero", rd0, 64'd0);
        chk("R10 alias read flag", 64'(un0), 64'd1);
        wr(A0 + 3, 64'd0);
        chk("R10 stray write flag", 64'(un0), 64'd1);
        rd(A0);
        chk("R10 stray write ignored", rd0, 64'hD000_0000_0000_0000);
        chk("R10 plain read no flag", 64'(un0), 64'd0);

        // R11 short and misaligned accesses
        op(1'b1, A0, 3'd0, 4'd4, 64'd0, 1'b0);
        chk("R11 short write flag", 64'(un0), 64'd1);
        op(1'b1, A0, 3'd4, 4'd8, 64'd0, 1'b0);
        chk("R11 misaligned flag", 64'(un0), 64'd1);
        op(1'b0, A0, 3'd0, 4'd2, 64'd0, 1'b0);
        chk("R11 short read zero", rd0, 64'd0);
        rd(A0);
        chk("R11 word untouched", rd0, 64'hD000_0000_0000_0000);

        // R5 clear variant
        wr(A1, 64'hFFFF_FFFF_FFFF_FFFF);
        chk("R7 u1 irq set", 64'(irq1), 64'd1);
        wr(A1 + 1, 64'hFFFF_FFFF_FFFF_FFFF);
        chk("R5 clear irq low", 64'(irq1), 64'd0);
        rd(A1);
        chk("R5 clear ignores data", rd1, 64'd0);
        wr(A1 + 2, 64'h0008_0000_0000_0000);
        rd(A1);
        chk("R4 or in clear variant", rd1, 64'h0008_0000_0000_0000);
        rd(A0);
        chk("R10 other variant flag", 64'(un1), 64'd1);
        chk("R10 other variant zero", rd1, 64'd0);

        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule